// File: doc/BRIEF.md
# Prescaler Core Timer with Periodic Interrupt and Watchdog

This block is a free-running binary divider chain driven by the peripheral clock. Taps on this single chain provide four services. The CPU can read an 8-bit count that advances once every four clocks. A timer overflow event occurs once per 1024 clocks. A periodic event has a rate chosen from four values between one per 2048 clocks and one per 16384 clocks. A watchdog counts periodic events and, unless software services it, emits a one-cycle reset pulse on the eighth event.

Software uses a small register bus with address, read strobe, write strobe and byte data. A control/status register holds two event flags, two interrupt enables, two write-one acknowledge bits and a 2-bit rate select. A third address is the watchdog service point. The interrupt request is a level output. The chip's power-on reset drives the synchronous reset input, which clears the whole chain.

Top module: `ptmr_core`

## Requirements
- R1: While `rst` is high at a rising edge, the chain, the flags, the enables, the rate select and the watchdog count all clear. After reset, the control/status register reads 0x00, the counter reads 0x00, and `irq` and `wdog_rst` are low.
- R2: Let N be the number of rising edges since the last reset edge. A read at address 0x09 returns (N/4) mod 256. Any address other than 0x08 and 0x09 reads 0x00. `rdata` is 0x00 whenever `rd_en` is low.
- R3: The overflow flag is bit 7 of the control/status register at address 0x08. It becomes set at every edge where N is a multiple of 1024.
- R4: The periodic flag is bit 6 of that register. It becomes set at every edge where N is a multiple of 2048·2^S, where S is the active rate select.
- R5: A write to 0x08 with bit 3 set clears the overflow flag. A write with bit 2 set clears the periodic flag. If a set event falls on the same edge as the clear, the set wins. A 0 in either bit leaves the flag alone. Bits 3 and 2 always read 0.
- R6: A write to 0x08 loads bit 5 (overflow interrupt enable), bit 4 (periodic interrupt enable) and bits 1:0 (requested rate select), and each of these reads back as written. Bits 7 and 6 cannot be written.
- R7: In the same cycle, `irq` equals (bit7 AND bit5) OR (bit6 AND bit4).
- R8: A new rate select becomes active only at the next edge where N is a multiple of 2048. Until that edge, the old rate applies.
- R9: The watchdog counts periodic events. On the eighth event since its last clear, `wdog_rst` is high for exactly one cycle.
- R10: A write of 0x00 to address 0x0F clears the watchdog count, and so does any write to 0x08 that changes the requested rate select. A write of a nonzero value to 0x0F has no effect. A clear on the same edge as a periodic event suppresses that event's pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset (power-on reset) |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational, zero when not reading |
| irq | output | 1 | Interrupt request level |
| wdog_rst | output | 1 | One-cycle watchdog reset pulse |

## Verification
A reference model in the bench predicts the flags, the interrupt level, every read value and the watchdog pulse, and the bench compares them every cycle. Long idle stretches after reset show the 1024-, 2048- and 16384-cycle event spacing. These stretches also show the first unserviced watchdog pulse, so a tap that is off by one stage shows up as a shifted cycle. Directed service writes separate a clearing write of 0x00 from an ignored nonzero write. A rate change made in the middle of a period shows whether the new rate waits for the 2048 boundary. Sparse random register traffic mixes acknowledges that coincide with set events, enable toggling and rate changes, which exercises the priority between set and clear and the same-cycle path to `irq`.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    localparam int DATA_W = 8;
    localparam int SEL_W  = 2;

    // control/status bit positions (software-visible layout)
    localparam int B_OVF_F   = 7;
    localparam int B_PER_F   = 6;
    localparam int B_OVF_EN  = 5;
    localparam int B_PER_EN  = 4;
    localparam int B_OVF_ACK = 3;
    localparam int B_PER_ACK = 2;

    typedef struct packed {
        logic ovf;
        logic per;
    } evt_t;

    function automatic logic [DATA_W-1:0] pack_csr(evt_t flg, evt_t en,
                                                   logic [SEL_W-1:0] sel);
        logic [DATA_W-1:0] v;
        v = '0;
        v[B_OVF_F]   = flg.ovf;
        v[B_PER_F]   = flg.per;
        v[B_OVF_EN]  = en.ovf;
        v[B_PER_EN]  = en.per;
        v[SEL_W-1:0] = sel;
        return v;
    endfunction

endpackage

// File: rtl/ptmr_chain.sv
module ptmr_chain
    import ptmr_pkg::*;
#(
    parameter int PRE_W = 2,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel_act,
    output logic [CNT_W-1:0] count,
    output logic             ovf_wrap,
    output logic             base_wrap,
    output logic             per_wrap
);
    localparam int OVF_W   = PRE_W + CNT_W;
    localparam int BASE_W  = OVF_W + 1;
    localparam int TAPS    = 1 << SEL_W;
    localparam int CHAIN_W = BASE_W + TAPS - 1;

    logic [CHAIN_W-1:0] chain;
    logic [TAPS-1:0]    tap_wrap;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= chain + 1'b1;
    end

    // one terminal-count detector per selectable periodic rate
    for (genvar i = 0; i < TAPS; i++) begin : g_tap
        assign tap_wrap[i] = &chain[BASE_W+i-1:0];
    end

    assign ovf_wrap  = &chain[OVF_W-1:0];
    assign base_wrap = tap_wrap[0];
    assign per_wrap  = tap_wrap[sel_act];
    assign count     = chain[OVF_W-1:PRE_W];

endmodule

// File: rtl/ptmr_regs.sv
module ptmr_regs
    import ptmr_pkg::*;
#(
    parameter int              ADDR_W   = 4,
    parameter int              CNT_W    = 8,
    parameter logic [ADDR_W-1:0] ADDR_CSR = ADDR_W'(8),
    parameter logic [ADDR_W-1:0] ADDR_CNT = ADDR_W'(9)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [5:0]        wbits,
    input  logic [CNT_W-1:0]  count,
    input  logic              ovf_wrap,
    input  logic              base_wrap,
    input  logic              per_wrap,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic [SEL_W-1:0]  sel_act,
    output logic              sel_chg,
    output evt_t              flags
);
    evt_t             en;
    evt_t             ack;
    logic [SEL_W-1:0] sel_req;
    logic             csr_wr;

    assign csr_wr  = wr_en && (addr == ADDR_CSR);
    assign ack.ovf = csr_wr && wbits[B_OVF_ACK];
    assign ack.per = csr_wr && wbits[B_PER_ACK];
    assign sel_chg = csr_wr && (wbits[SEL_W-1:0] != sel_req);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags   <= '0;
            en      <= '0;
            sel_req <= '0;
            sel_act <= '0;
        end else begin
            // a set event outranks an acknowledge on the same edge
            flags.ovf <= ovf_wrap || (flags.ovf && !ack.ovf);
            flags.per <= per_wrap || (flags.per && !ack.per);
            if (csr_wr) begin
                en.ovf  <= wbits[B_OVF_EN];
                en.per  <= wbits[B_PER_EN];
                sel_req <= wbits[SEL_W-1:0];
            end
            if (base_wrap) sel_act <= sel_req;
        end
    end

    assign irq = (flags.ovf && en.ovf) || (flags.per && en.per);

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (addr == ADDR_CNT)      rdata = DATA_W'(count);
            else if (addr == ADDR_CSR) rdata = pack_csr(flags, en, sel_req);
        end
    end

endmodule

// File: rtl/ptmr_wdog.sv
module ptmr_wdog #(
    parameter int WD_W = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic clr,
    output logic bite
);
    logic [WD_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            bite <= 1'b0;
        end else begin
            bite <= tick && (&cnt) && !clr;
            if (clr)       cnt <= '0;
            else if (tick) cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/ptmr_core.sv
module ptmr_core
    import ptmr_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int PRE_W  = 2,
    parameter int CNT_W  = 8,
    parameter int WD_W   = 3,
    parameter logic [ADDR_W-1:0] ADDR_CSR = ADDR_W'(8),
    parameter logic [ADDR_W-1:0] ADDR_CNT = ADDR_W'(9),
    parameter logic [ADDR_W-1:0] ADDR_WDC = ADDR_W'(15)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic              wdog_rst
);
    logic [CNT_W-1:0] count;
    logic             ovf_wrap, base_wrap, per_wrap;
    logic [SEL_W-1:0] sel_act;
    logic             sel_chg;
    logic             wdc_hit;
    evt_t             flg;

    assign wdc_hit = wr_en && (addr == ADDR_WDC) && (wdata == '0);

    ptmr_chain #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_chain (
        .clk(clk), .rst(rst), .sel_act(sel_act), .count(count),
        .ovf_wrap(ovf_wrap), .base_wrap(base_wrap), .per_wrap(per_wrap)
    );

    ptmr_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W),
                .ADDR_CSR(ADDR_CSR), .ADDR_CNT(ADDR_CNT)) u_regs (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wbits(wdata[5:0]), .count(count), .ovf_wrap(ovf_wrap),
        .base_wrap(base_wrap), .per_wrap(per_wrap), .rdata(rdata),
        .irq(irq), .sel_act(sel_act), .sel_chg(sel_chg), .flags(flg)
    );

    ptmr_wdog #(.WD_W(WD_W)) u_wdog (
        .clk(clk), .rst(rst), .tick(per_wrap),
        .clr(wdc_hit || sel_chg), .bite(wdog_rst)
    );

endmodule

// File: rtl/ptmr_core_chk.sv
module ptmr_core_chk
    import ptmr_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] ADDR_CSR = ADDR_W'(8),
    parameter logic [ADDR_W-1:0] ADDR_WDC = ADDR_W'(15)
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [DATA_W-1:0] wdata,
    input logic              wdog_rst,
    input logic              ovf_flag,
    input logic              per_flag,
    input logic              ovf_wrap,
    input logic              base_wrap,
    input logic              per_wrap,
    input logic [SEL_W-1:0]  sel_act
);
    // R3
    ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_flag) |-> $past(ovf_wrap));

    // R4
    per_set_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(per_flag) |-> $past(per_wrap));

    // R5
    ovf_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_CSR && wdata[B_OVF_ACK] && !ovf_wrap) |=> !ovf_flag);

    // R8
    sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sel_act) |-> $past(base_wrap));

    // R9
    bite_once_chk: assert property (@(posedge clk) disable iff (rst)
        wdog_rst |=> !wdog_rst);

    // R9
    bite_src_chk: assert property (@(posedge clk) disable iff (rst)
        wdog_rst |-> $past(per_wrap));

    // R10
    wdc_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_WDC && wdata == '0) |=> !wdog_rst);

endmodule

bind ptmr_core ptmr_core_chk #(
    .ADDR_W(ADDR_W), .ADDR_CSR(ADDR_CSR), .ADDR_WDC(ADDR_WDC)
) u_chk (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .wdog_rst(wdog_rst), .ovf_flag(flg.ovf), .per_flag(flg.per),
    .ovf_wrap(ovf_wrap), .base_wrap(base_wrap), .per_wrap(per_wrap),
    .sel_act(sel_act)
);

// File: tb/tb_ptmr_core.sv
module tb_ptmr_core;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] addr = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;
    logic       wdog_rst;

    int checks = 0;
    int fails  = 0;
    int bites  = 0;
    bit done   = 0;

    // reference model state
    int unsigned m_n = 0;
    int unsigned m_wd = 0;
    int unsigned per_len;
    logic m_of = 0, m_pf = 0, m_oe = 0, m_pe = 0, m_bite = 0;
    logic [1:0] m_sr = 0, m_sa = 0;
    logic ovf_ev, base_ev, per_ev, csr_w, wdc_w, chg, clr;

    ptmr_core dut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .irq(irq), .wdog_rst(wdog_rst)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(logic [3:0] a);
        if (a == 4'h9) return 8'((m_n >> 2) & 255);
        if (a == 4'h8) return {m_of, m_pf, m_oe, m_pe, 2'b00, m_sr};
        return 8'h00;
    endfunction

    // reference model, advanced on each rising edge from the stable inputs
    always @(posedge clk) begin
        if (rst) begin
            m_n = 0; m_wd = 0; m_of = 0; m_pf = 0; m_oe = 0; m_pe = 0;
            m_sr = 0; m_sa = 0; m_bite = 0;
        end else begin
            per_len = 32'd2048 << m_sa;
            ovf_ev  = (m_n % 1024) == 1023;
            base_ev = (m_n % 2048) == 2047;
            per_ev  = (m_n % per_len) == per_len - 1;
            csr_w   = wr_en && addr == 4'h8;
            wdc_w   = wr_en && addr == 4'hF && wdata == 8'h00;
            chg     = csr_w && wdata[1:0] != m_sr;
            clr     = wdc_w || chg;
            m_bite  = per_ev && m_wd == 7 && !clr;
            m_wd    = clr ? 0 : (per_ev ? (m_wd + 1) % 8 : m_wd);
            if (base_ev) m_sa = m_sr;
            m_of = ovf_ev || (m_of && !(csr_w && wdata[3]));
            m_pf = per_ev || (m_pf && !(csr_w && wdata[2]));
            if (csr_w) begin
                m_oe = wdata[5]; m_pe = wdata[4]; m_sr = wdata[1:0];
            end
            m_n = m_n + 1;
        end
    end

    // per-cycle comparison, a quarter period after the falling edge
    always @(negedge clk) begin
        #(CLK_P/4);
        if (!rst && !done) begin
            chk("R7 irq", irq, (m_of && m_oe) || (m_pf && m_pe));
            chk("R9 R10 wdog_rst", wdog_rst, m_bite);
            if (wdog_rst) bites++;
            if (rd_en) begin
                if (addr == 4'h9)      chk("R2 counter read", rdata, exp_read(addr));
                else if (addr == 4'h8) chk("R3 R4 R5 R6 csr read", rdata, exp_read(addr));
                else                   chk("R2 unmapped read", rdata, 8'h00);
            end else begin
                chk("R2 idle rdata", rdata, 8'h00);
            end
        end
    end

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic do_write(logic [3:0] a, logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic do_read(logic [3:0] a, output logic [7:0] v);
        @(negedge clk); addr = a; rd_en = 1'b1;
        #(CLK_P/4); v = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic wait_n(int unsigned t);
        while (m_n < t) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog timeout actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        int unsigned r;
        int b0;
        r = $urandom(32'h5EED_0042);

        // R1: reset state
        do_reset();
        do_read(4'h8, v); chk("R1 csr after reset", v, 8'h00);
        do_read(4'h9, v); chk("R1 counter after reset", v, 8'h00);
        chk("R1 irq after reset", irq, 1'b0);
        chk("R1 wdog_rst after reset", wdog_rst, 1'b0);

        // R6 enables, R3 overflow at 1024 edges, R7 irq, R5 ack
        do_write(4'h8, 8'h30);
        do_read(4'h8, v); chk("R6 enables read back", v, 8'h30);
        wait_n(1020);
        chk("R3 flag clear before 1024", irq, 1'b0);
        wait_n(1026);
        chk("R3 R7 irq after overflow", irq, 1'b1);
        do_write(4'h8, 8'hFF);
        do_read(4'h8, v); chk("R5 R6 ack clears, flags not writable", v, 8'h33);
        do_write(4'h8, 8'h30);
        do_write(4'h8, 8'h3C);
        do_read(4'h8, v); chk("R5 both acked", v, 8'h30);

        // R9: unserviced watchdog fires once at edge 16384 with rate 0
        b0 = bites;
        wait_n(16400);
        chk("R9 one pulse after eight periods", bites - b0, 1);

        // R10: nonzero write ignored, zero write services
        do_reset();
        wait_n(9000);
        do_write(4'hF, 8'h55);
        b0 = bites;
        wait_n(16400);
        chk("R10 nonzero service ignored", bites - b0, 1);
        do_reset();
        wait_n(15000);
        do_write(4'hF, 8'h00);
        b0 = bites;
        wait_n(16500);
        chk("R10 zero write services", bites - b0, 0);

        // R8: rate change mid-period waits for the 2048 boundary
        do_reset();
        do_write(4'h8, 8'h11);
        wait_n(2100);
        do_write(4'h8, 8'h14);
        wait_n(3000);
        do_write(4'h8, 8'h12);
        wait_n(20000);
        do_read(4'h8, v); chk("R8 rate select read back", v[1:0], 2'b10);

        // mixed random traffic against the model
        for (int i = 0; i < 60000; i++) begin
            r = $urandom;
            if (r[5:0] == 6'd0) begin
                do_write(4'h8, 8'($urandom));
            end else if (r[13:6] == 8'd0) begin
                do_write(4'hF, r[14] ? 8'h00 : 8'($urandom));
            end else if (r[17:15] == 3'd0) begin
                case (r[19:18])
                    2'd0: do_read(4'h8, v);
                    2'd1: do_read(4'h9, v);
                    2'd2: do_read(4'hF, v);
                    default: do_read(4'h3, v);
                endcase
            end else begin
                @(negedge clk);
            end
        end

        @(negedge clk);
        finish_run();
    end

endmodule